// File: doc/BRIEF.md
# Buffered PWM Register Reload Controller

A free-running up-counter for pulse-width modulation with double-buffered period, start and per-channel compare registers. Software writes new settings through a small register port. A write only reaches a shadow (buffer) register, so the settings the counter uses never change in the middle of a period unless software asks for it.

Shadow values move into the active registers together, in one clock, at a synchronization point. There are two kinds of point. The first is the step where the counter leaves its terminal value. The second is a compare match on any channel that software has picked in a per-channel mask. A single arm bit gates every transfer. It clears itself once a transfer has happened, so each update must be armed again on purpose. The block drives the counter value, one match strobe per channel and the active register values.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After a synchronous reset, the counter, all active registers, all shadow registers, the arm bit and the channel mask are zero.
- R2: While `run` is 1, the counter goes up by one each clock until it equals the active terminal value. On the next clock it loads the active start value. While `run` is 0, the counter holds its value.
- R3: Register map, by word address: 0 is the terminal value, 1 is the start value, 2 is the control word, and 8+j is the compare value of channel j. Reads are combinational. Writes to addresses 0, 1 and 8+j change only the shadow registers. Reads of those addresses return the active values.
- R4: When the arm bit is 1 at a synchronization point, all shadow values are copied into the active registers on that clock edge.
- R5: A clock with `run`=1 in which the counter equals channel j's active compare value is a synchronization point only if bit j of the channel mask is 1. A match on a channel whose mask bit is 0 causes no transfer.
- R6: While the arm bit is 0, the active registers do not change, whatever the counter does.
- R7: The arm bit clears on the edge that performs a transfer. This takes priority over a control write in the same clock.
- R8: In the control word, bits 7:0 are the channel mask (bit j for channel j) and bit 9 is the arm bit. All other bits ignore writes and read as zero.
- R9: A shadow write in the same clock as a transfer does not take part in that transfer. The transfer copies the earlier shadow contents, and the new value waits for the next synchronization point.
- R10: `match[j]` is 1 exactly in the clocks where `run` is 1 and the counter equals channel j's active compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counter enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| count | output | CNT_W (16) | Counter value |
| match | output | NUM_CH (8) | Per-channel compare match strobes |
| mod_q | output | CNT_W | Active terminal value |
| init_q | output | CNT_W | Active start value |
| cmp_q | output | NUM_CH*CNT_W | Active compare values, channel j at bits j*CNT_W upward |

## Verification
A transfer that fires at the wrong time shows on `mod_q`, `init_q` or `cmp_q` at the very next clock. A transfer that takes the wrong contents shows there as well. An arm bit that is stuck or is not cleared shows on a read of address 2, in the same clock that the address is presented. A wrong counter step, or a stale active value feeding the counter, shows on `count` and `match` within one period. The bench also flags it through the comparison of every port in every cycle.

// File: rtl/pwm_reload_pkg.sv
package pwm_reload_pkg;

    parameter int unsigned PRR_CNT_W  = 16;
    parameter int unsigned PRR_NUM_CH = 8;
    parameter int unsigned PRR_ARM_BIT = 9;

    typedef enum logic [1:0] {
        SEL_TERM  = 2'd0,
        SEL_START = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } low_sel_e;

    typedef struct packed {
        logic       arm;
        logic [7:0] mask;
    } ctrl_t;

    function automatic logic [31:0] ctrl_word(input ctrl_t c);
        logic [31:0] w;
        w = 32'd0;
        w[PRR_ARM_BIT] = c.arm;
        w[7:0] = c.mask;
        return w;
    endfunction

    function automatic low_sel_e low_decode(input logic [1:0] a);
        low_decode = low_sel_e'(a);
    endfunction

endpackage

// File: rtl/prr_counter.sv
module prr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] term_act,
    input  logic [CNT_W-1:0] start_act,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    assign wrap = run && (count == term_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (run) begin
            if (wrap) count <= start_act;
            else      count <= count + 1'b1;
        end
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && count != term_act) |=> count == $past(count) + 1'b1);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));

endmodule

// File: rtl/prr_loadpt.sv
module prr_loadpt #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 8
) (
    input  logic                         run,
    input  logic [CNT_W-1:0]             count,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act,
    input  logic [NUM_CH-1:0]            mask,
    input  logic                         wrap,
    input  logic                         arm,
    output logic [NUM_CH-1:0]            match,
    output logic                         load_fire
);
    logic chan_pt;

    for (genvar j = 0; j < NUM_CH; j++) begin : g_cmp
        assign match[j] = run && (count == cmp_act[j]);
    end

    assign chan_pt   = |(match & mask);
    assign load_fire = arm && (wrap || chan_pt);

endmodule

// File: rtl/prr_active.sv
module prr_active #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load_fire,
    input  logic [CNT_W-1:0]             term_buf,
    input  logic [CNT_W-1:0]             start_buf,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf,
    output logic [CNT_W-1:0]             term_act,
    output logic [CNT_W-1:0]             start_act,
    output logic [NUM_CH-1:0][CNT_W-1:0] cmp_act
);
    always_ff @(posedge clk) begin
        if (rst) begin
            term_act  <= '0;
            start_act <= '0;
        end else if (load_fire) begin
            term_act  <= term_buf;
            start_act <= start_buf;
        end
    end

    for (genvar j = 0; j < NUM_CH; j++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)            cmp_act[j] <= '0;
            else if (load_fire) cmp_act[j] <= cmp_buf[j];
        end
    end

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_fire |=> ($stable(term_act) && $stable(start_act) && $stable(cmp_act)));

    // R4
    act_copy_chk: assert property (@(posedge clk) disable iff (rst)
        load_fire |=> (term_act == $past(term_buf) && start_act == $past(start_buf)));

endmodule

// File: rtl/prr_regs.sv
module prr_regs
    import pwm_reload_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CH_AW  = 3,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_wr,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [31:0]                  reg_wdata,
    input  logic                         load_fire,
    input  logic [CNT_W-1:0]             term_act,
    input  logic [CNT_W-1:0]             start_act,
    input  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0]             term_buf,
    output logic [CNT_W-1:0]             start_buf,
    output logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf,
    output logic [NUM_CH-1:0]            mask,
    output logic                         arm,
    output logic [31:0]                  reg_rdata
);
    logic           is_cmp;
    logic [CH_AW-1:0] ch_idx;
    low_sel_e       lsel;
    ctrl_t          cview;

    assign is_cmp = reg_addr[CH_AW];
    assign ch_idx = reg_addr[CH_AW-1:0];
    assign lsel   = low_decode(reg_addr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            term_buf  <= '0;
            start_buf <= '0;
            mask      <= '0;
            arm       <= 1'b0;
        end else begin
            if (reg_wr && !is_cmp && reg_addr[CH_AW-1:2] == '0) begin
                case (lsel)
                    SEL_TERM:  term_buf  <= reg_wdata[CNT_W-1:0];
                    SEL_START: start_buf <= reg_wdata[CNT_W-1:0];
                    SEL_CTRL: begin
                        mask <= reg_wdata[NUM_CH-1:0];
                        arm  <= reg_wdata[PRR_ARM_BIT];
                    end
                    default: ;
                endcase
            end
            if (load_fire) arm <= 1'b0;
        end
    end

    for (genvar j = 0; j < NUM_CH; j++) begin : g_buf
        always_ff @(posedge clk) begin
            if (rst)
                cmp_buf[j] <= '0;
            else if (reg_wr && is_cmp && ch_idx == CH_AW'(j))
                cmp_buf[j] <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        cview      = '0;
        cview.arm  = arm;
        cview.mask[NUM_CH-1:0] = mask;
        reg_rdata  = 32'd0;
        if (is_cmp) begin
            reg_rdata[CNT_W-1:0] = cmp_act[ch_idx];
        end else if (reg_addr[CH_AW-1:2] == '0) begin
            case (lsel)
                SEL_TERM:  reg_rdata[CNT_W-1:0] = term_act;
                SEL_START: reg_rdata[CNT_W-1:0] = start_act;
                SEL_CTRL:  reg_rdata = ctrl_word(cview);
                default:   reg_rdata = 32'd0;
            endcase
        end
    end

    // R7
    arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        load_fire |=> !arm);

    // R3
    term_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == ADDR_W'(0)) |=> term_buf == $past(reg_wdata[CNT_W-1:0]));

endmodule

// File: rtl/pwm_reload_ctrl.sv
module pwm_reload_ctrl
    import pwm_reload_pkg::*;
#(
    parameter int unsigned CNT_W  = PRR_CNT_W,
    parameter int unsigned NUM_CH = PRR_NUM_CH,
    parameter int unsigned CH_AW  = (NUM_CH > 4) ? $clog2(NUM_CH) : 2,
    parameter int unsigned ADDR_W = CH_AW + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    output logic [CNT_W-1:0]        count,
    output logic [NUM_CH-1:0]       match,
    output logic [CNT_W-1:0]        mod_q,
    output logic [CNT_W-1:0]        init_q,
    output logic [NUM_CH*CNT_W-1:0] cmp_q
);
    logic [CNT_W-1:0]             term_buf, start_buf, term_act, start_act;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_buf, cmp_act;
    logic [NUM_CH-1:0]            mask;
    logic                         arm, wrap, load_fire;

    prr_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .CH_AW(CH_AW), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .load_fire(load_fire),
        .term_act(term_act), .start_act(start_act), .cmp_act(cmp_act),
        .term_buf(term_buf), .start_buf(start_buf), .cmp_buf(cmp_buf),
        .mask(mask), .arm(arm), .reg_rdata(reg_rdata)
    );

    prr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(run), .term_act(term_act),
        .start_act(start_act), .count(count), .wrap(wrap)
    );

    prr_loadpt #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_lp (
        .run(run), .count(count), .cmp_act(cmp_act), .mask(mask),
        .wrap(wrap), .arm(arm), .match(match), .load_fire(load_fire)
    );

    prr_active #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_act (
        .clk(clk), .rst(rst), .load_fire(load_fire),
        .term_buf(term_buf), .start_buf(start_buf), .cmp_buf(cmp_buf),
        .term_act(term_act), .start_act(start_act), .cmp_act(cmp_act)
    );

    assign mod_q  = term_act;
    assign init_q = start_act;
    assign cmp_q  = cmp_act;

    // R1
    rst_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> (count == '0 && !arm && term_act == '0));

endmodule

// File: tb/pwm_reload_ctrl_bench.sv
module pwm_reload_ctrl_bench;
    localparam int W = 16;
    localparam int N = 8;

    logic clk = 1'b0, rst = 1'b1, run = 1'b0, reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [W-1:0] count, mod_q, init_q;
    logic [N-1:0] match;
    logic [N*W-1:0] cmp_q;

    pwm_reload_ctrl u_pwm_reload_ctrl (
        .clk(clk), .rst(rst), .run(run), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count), .match(match),
        .mod_q(mod_q), .init_q(init_q), .cmp_q(cmp_q)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [W-1:0] m_cnt, m_mod, m_init, b_mod, b_init;
    logic [W-1:0] m_cmp [N];
    logic [W-1:0] b_cmp [N];
    logic [N-1:0] m_sel;
    logic m_arm;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [N*W-1:0] m_cmp_flat();
        logic [N*W-1:0] f;
        for (int j = 0; j < N; j++) f[j*W +: W] = m_cmp[j];
        return f;
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        if (a[3]) return {16'd0, m_cmp[a[2:0]]};
        case (a)
            4'd0: return {16'd0, m_mod};
            4'd1: return {16'd0, m_init};
            4'd2: return {22'd0, m_arm, 1'b0, m_sel};
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [N-1:0] m_match(input logic r);
        logic [N-1:0] v;
        for (int j = 0; j < N; j++) v[j] = r && (m_cnt == m_cmp[j]);
        return v;
    endfunction

    task automatic m_reset();
        m_cnt = 0; m_mod = 0; m_init = 0; b_mod = 0; b_init = 0;
        m_sel = 0; m_arm = 0;
        for (int j = 0; j < N; j++) begin m_cmp[j] = 0; b_cmp[j] = 0; end
    endtask

    task automatic check_state();
        chk("R2 count", 128'(count), 128'(m_cnt));
        chk("R4 terminal", 128'(mod_q), 128'(m_mod));
        chk("R4 start", 128'(init_q), 128'(m_init));
        chk("R4 compare", 128'(cmp_q), 128'(m_cmp_flat()));
    endtask

    // one clock: drive inputs, check combinational outputs, advance model
    task automatic cyc(input logic r, input logic w, input logic [3:0] a, input logic [31:0] d);
        logic [N-1:0] mm;
        logic roll, fire;
        logic [W-1:0] nxt;
        run = r; reg_wr = w; reg_addr = a; reg_wdata = d;
        #1;
        mm = m_match(r);
        chk("R10 match", 128'(match), 128'(mm));
        chk("R3 read", 128'(reg_rdata), 128'(m_read(a)));
        roll = r && (m_cnt == m_mod);
        fire = m_arm && (roll || |(mm & m_sel));
        nxt = r ? (roll ? m_init : m_cnt + 1'b1) : m_cnt;
        @(posedge clk);
        #1;
        if (fire) begin
            m_mod = b_mod; m_init = b_init;
            for (int j = 0; j < N; j++) m_cmp[j] = b_cmp[j];
        end
        m_cnt = nxt;
        if (w) begin
            if (a[3]) b_cmp[a[2:0]] = d[W-1:0];
            else if (a == 4'd0) b_mod = d[W-1:0];
            else if (a == 4'd1) b_init = d[W-1:0];
            else if (a == 4'd2) begin m_sel = d[7:0]; m_arm = d[9]; end
        end
        if (fire) m_arm = 0;
        @(negedge clk);
        check_state();
    endtask

    task automatic run_until_count(input logic [W-1:0] v);
        for (int i = 0; i < 200 && m_cnt != v; i++) cyc(1, 0, 4'd2, 0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_reset();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", 128'(count), 128'd0);
        chk("R1 terminal", 128'(mod_q), 128'd0);
        chk("R1 compare", 128'(cmp_q), 128'd0);
        reg_addr = 4'd2; #1;
        chk("R1 control", 128'(reg_rdata), 128'd0);
        @(negedge clk);

        // R6: buffered, arm clear -> nothing moves
        cyc(0, 1, 4'd0, 32'd5);
        cyc(0, 1, 4'd1, 32'd2);
        repeat (4) cyc(1, 0, 4'd0, 0);
        chk("R6 terminal unchanged", 128'(mod_q), 128'd0);
        chk("R3 read shows active", 128'(reg_rdata), 128'd0);

        // R4/R7: arm, rollover transfers, arm self-clears
        cyc(0, 1, 4'd2, 32'h200);
        cyc(1, 0, 4'd2, 0);
        chk("R4 terminal loaded", 128'(mod_q), 128'd5);
        chk("R4 start loaded", 128'(init_q), 128'd2);
        reg_addr = 4'd2; #1;
        chk("R7 arm cleared", 128'(reg_rdata), 128'd0);
        repeat (8) cyc(1, 0, 4'd1, 0);

        // R9: buffer write in transfer cycle uses old contents
        cyc(1, 1, 4'd0, 32'd7);
        cyc(1, 1, 4'd2, 32'h200);
        run_until_count(5);
        cyc(1, 1, 4'd0, 32'd9);
        chk("R9 old buffer used", 128'(mod_q), 128'd7);
        cyc(1, 1, 4'd2, 32'h200);
        run_until_count(7);
        cyc(1, 0, 4'd0, 0);
        chk("R9 new value next point", 128'(mod_q), 128'd9);

        // R5: selected channel match is a load point
        cyc(1, 1, 4'd11, 32'd4);
        cyc(1, 1, 4'd2, 32'h200);
        run_until_count(9);
        cyc(1, 0, 4'd0, 0);
        cyc(1, 1, 4'd1, 32'd1);
        cyc(1, 1, 4'd2, 32'h208);
        run_until_count(4);
        cyc(1, 0, 4'd0, 0);
        chk("R5 selected match loads", 128'(init_q), 128'd1);
        // R5: unselected channel match does not load
        cyc(1, 1, 4'd1, 32'd3);
        run_until_count(9);
        cyc(1, 0, 4'd0, 0);
        cyc(1, 1, 4'd2, 32'h204);
        run_until_count(4);
        cyc(1, 0, 4'd0, 0);
        chk("R5 unselected no load", 128'(init_q), 128'd1);

        // R8: reserved control bits
        cyc(0, 1, 4'd2, 32'hFFFF_FFFF);
        reg_addr = 4'd2; #1;
        chk("R8 control readback", 128'(reg_rdata), 128'h2FF);
        cyc(0, 1, 4'd2, 32'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic r, w;
            logic [3:0] a;
            logic [31:0] d;
            r = ($urandom % 16) != 0;
            w = ($urandom % 3) == 0;
            case ($urandom % 4)
                0: begin a = 4'd0; d = 32'd4 + ($urandom % 28); end
                1: begin a = 4'd1; d = $urandom % 8; end
                2: begin a = 4'd2; d = ($urandom & 32'hFFFF_FDFF) | (($urandom % 2) << 9); end
                default: begin a = 4'(8 + ($urandom % 8)); d = $urandom % 32; end
            endcase
            if (!w && ($urandom % 2)) a = 4'($urandom % 16);
            cyc(r, w, a, d);
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule